// File: doc/BRIEF.md
# Serial Result Shifter with Tag Passthrough

This block is the output stage of a sampling device. It sends a finished 16-bit result as a serial frame, clocked by a data clock that the host supplies. Every input is sampled on the rising edge of that clock. The block's registers also run on it.

A result is captured from the parallel word by a load strobe. It then waits until a read request arrives. Each frame has three parts, in this order:
- a one-clock frame marker on `sync_o`;
- the sixteen result bits, most significant bit first;
- after the last result bit, `data_o` forwards the `tag_i` input through a fixed sixteen-clock delay.

Because of the tag stage, several devices can share one data line. Each device's `data_o` feeds the next device's `tag_i`. The host then reads every result in turn from the last device, on one continuous run of clocks.

Top module: `serial_result_shifter`

## Requirements
- R1: `sync_o` rises on the first data-clock rising edge at which `rd_req_i` is high and a result is available. It stays high for exactly one clock unless another request restarts the frame.
- R2: `data_o` is low while `sync_o` is high. On the next rising edge, `sync_o` falls and `data_o` presents bit 15 (the MSB) of the captured word.
- R3: Each following rising edge presents the next lower bit. Bit 0 (the LSB) is presented on the 16th rising edge after the edge that raised `sync_o`.
- R4: On the rising edge after the LSB, `data_o` takes the value of `tag_i` that was sampled on the edge that presented the MSB.
- R5: After that, `data_o` keeps following `tag_i` with a delay of exactly 16 clocks, for as long as clocks are supplied and no new frame starts.
- R6: A read request that arrives during a frame, while a result is available, restarts the frame from the `sync_o` pulse with the new word.
- R7: After reset, `sync_o` and `data_o` are low. `data_o` stays low until the first frame starts.
- R8: A load strobe during a frame does not change the bits of the word being shifted. The new word is served by the next frame.
- R9: A result is available from a load until the start of the frame that takes it. A read request with no result available has no effect: no `sync_o` pulse, and no change to the stream on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk_i | input | 1 | Externally supplied data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 16 | Parallel result word |
| load_i | input | 1 | Captures `word_i` as the available result |
| rd_req_i | input | 1 | Read request, starts a frame |
| tag_i | input | 1 | Serial data from the previous device in the chain |
| sync_o | output | 1 | One-clock frame marker |
| data_o | output | 1 | Serial result, then delayed tag stream |

## Verification
Four words are shifted out:
- 16'h8001 puts a lone one at each end of the frame, which exposes an off-by-one in the bit count.
- 16'hFFFF shows whether the stage leaks a constant where a bit belongs.
- 16'h0000 does the same for the opposite constant.
- 16'hA5C3 shows the bit order.

The tag input carries a pseudo-random stream, so a wrong tag delay produces a mismatch rather than an accidental match. Further directed runs cover these cases:
- a load in the middle of a frame;
- a request in the middle of a frame, which restarts it;
- requests with no result available, both right after reset and while tags are passing through.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAG   = 2'd3
  } frame_st_e;
endpackage

// File: rtl/srs_result_hold.sv
module srs_result_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         take_i,
  output logic [W-1:0] hold_o,
  output logic         ready_o
);
  logic [W-1:0] hold_q;
  logic         ready_q, ready_d;

  always_comb begin
    ready_d = ready_q;
    if (take_i) ready_d = 1'b0;
    if (load_i) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
      if (load_i) hold_q <= word_i;
    end
  end

  assign hold_o  = hold_q;
  assign ready_o = ready_q;

  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !load_i) |=> !ready_o); // R9
  AST_TAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> ready_o); // R9
endmodule

// File: rtl/srs_tag_delay.sv
module srs_tag_delay #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_i,
  output logic tag_o
);
  logic [DEPTH-1:0] dly_q, dly_d;

  always_comb dly_d = {dly_q[DEPTH-2:0], tag_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  assign tag_o = dly_q[DEPTH-1];
endmodule

// File: rtl/srs_frame_ctrl.sv
module srs_frame_ctrl
  import srs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  input  logic         tag_dly_i,
  output logic         sync_o,
  output logic         data_o
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  frame_st_e    st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0] sh_q, sh_d;
  logic         dat_q, dat_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    dat_d = dat_q;
    if (start_i) begin
      st_d  = ST_SYNC;
      sh_d  = word_i;
      cnt_d = '0;
      dat_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: dat_d = 1'b0;
        ST_SYNC: begin
          dat_d = sh_q[W-1];
          sh_d  = {sh_q[W-2:0], 1'b0};
          cnt_d = CNT_W'(1);
          st_d  = ST_SHIFT;
        end
        ST_SHIFT: begin
          if (cnt_q == LAST) begin
            dat_d = tag_dly_i;
            st_d  = ST_TAG;
          end else begin
            dat_d = sh_q[W-1];
            sh_d  = {sh_q[W-2:0], 1'b0};
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_TAG:  dat_d = tag_dly_i;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      dat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
    end
  end

  assign sync_o = (st_q == ST_SYNC);
  assign data_o = dat_q;

  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && !start_i) |=> !sync_o); // R1
  AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(start_i)); // R1
  AST_SYNC_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> !data_o); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
  AST_TAG_AFTER_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAG && $past(st_q) == ST_SHIFT) |-> data_o == $past(tag_dly_i)); // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !data_o); // R7
endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter #(
  parameter int W = 16
) (
  input  logic         dclk_i,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         load_i,
  input  logic         rd_req_i,
  input  logic         tag_i,
  output logic         sync_o,
  output logic         data_o
);
  localparam int TAG_DEPTH = W;

  logic [W-1:0] hold_w;
  logic         ready_w;
  logic         start_w;
  logic         tag_dly_w;

  assign start_w = rd_req_i & ready_w;

  srs_result_hold #(.W(W)) u_hold (
    .clk     (dclk_i),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .word_i  (word_i),
    .take_i  (start_w),
    .hold_o  (hold_w),
    .ready_o (ready_w)
  );

  srs_tag_delay #(.DEPTH(TAG_DEPTH)) u_tag (
    .clk   (dclk_i),
    .rst_n (rst_n),
    .tag_i (tag_i),
    .tag_o (tag_dly_w)
  );

  srs_frame_ctrl #(.W(W)) u_ctrl (
    .clk       (dclk_i),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .word_i    (hold_w),
    .tag_dly_i (tag_dly_w),
    .sync_o    (sync_o),
    .data_o    (data_o)
  );

  AST_NO_SYNC_WITHOUT_REQ: assert property (@(posedge dclk_i) disable iff (!rst_n)
    $rose(sync_o) |-> $past(rd_req_i)); // R9
endmodule

// File: tb/tb_serial_result_shifter.sv
module tb_serial_result_shifter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] word;
  logic        load, rd_req, tag;
  logic        sync_o, data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] lfsr = 8'h5B;
  logic tag_hist [0:63];

  always #10 clk = ~clk;

  serial_result_shifter dut (
    .dclk_i(clk), .rst_n(rst_n), .word_i(word), .load_i(load),
    .rd_req_i(rd_req), .tag_i(tag), .sync_o(sync_o), .data_o(data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic next_tag();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[0];
  endfunction

  task automatic load_word(input logic [15:0] w);
    word = w; load = 1'b1;
    step();
    load = 1'b0;
  endtask

  // Full frame: SYNC, 16 bits, then ntag delayed tags. Optional mid-frame load.
  task automatic run_frame(input logic [15:0] w, input int ntag, input bit mid, input logic [15:0] mid_w);
    rd_req = 1'b1;
    tag = next_tag();
    step();
    rd_req = 1'b0;
    chk(sync_o == 1'b1, "R1 sync high", sync_o, 1);
    chk(data_o == 1'b0, "R2 data low in sync", data_o, 0);
    tag_hist[0] = next_tag(); tag = tag_hist[0];
    step();
    chk(sync_o == 1'b0, "R1 sync one clock", sync_o, 0);
    chk(data_o == w[15], "R2 msb", data_o, w[15]);
    for (int k = 1; k < 16; k++) begin
      load = 1'b0;
      if (mid && k == 5) begin word = mid_w; load = 1'b1; end
      tag_hist[k] = next_tag(); tag = tag_hist[k];
      step();
      chk(data_o == w[15-k], mid ? "R8 bit kept" : "R3 bit order", data_o, w[15-k]);
      chk(sync_o == 1'b0, "R1 sync low in shift", sync_o, 0);
    end
    load = 1'b0;
    for (int j = 0; j < ntag; j++) begin
      tag_hist[16+j] = next_tag(); tag = tag_hist[16+j];
      step();
      chk(data_o == tag_hist[j], j == 0 ? "R4 first tag" : "R5 tag delay", data_o, tag_hist[j]);
    end
  endtask

  task automatic test_reset();
    chk(sync_o == 1'b0, "R7 reset sync", sync_o, 0);
    chk(data_o == 1'b0, "R7 reset data", data_o, 0);
  endtask

  task automatic test_no_result_after_reset();
    rd_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tag = next_tag();
      step();
      chk(sync_o == 1'b0, "R9 no sync without result", sync_o, 0);
      chk(data_o == 1'b0, "R7 R9 data stays low", data_o, 0);
    end
    rd_req = 1'b0;
  endtask

  task automatic test_patterns();
    load_word(16'h8001); run_frame(16'h8001, 4, 1'b0, 16'h0);
    load_word(16'hFFFF); run_frame(16'hFFFF, 4, 1'b0, 16'h0);
    load_word(16'h0000); run_frame(16'h0000, 4, 1'b0, 16'h0);
    load_word(16'hA5C3); run_frame(16'hA5C3, 24, 1'b0, 16'h0);
  endtask

  task automatic test_no_result_in_tag();
    // previous frame consumed the result; requests must not disturb the tag stream
    for (int j = 0; j < 16; j++) begin
      tag_hist[j] = next_tag(); tag = tag_hist[j];
      step();
    end
    rd_req = 1'b1;
    for (int j = 0; j < 6; j++) begin
      tag_hist[16+j] = next_tag(); tag = tag_hist[16+j];
      step();
      chk(sync_o == 1'b0, "R9 request ignored", sync_o, 0);
      chk(data_o == tag_hist[j], "R9 tag stream undisturbed", data_o, tag_hist[j]);
    end
    rd_req = 1'b0;
  endtask

  task automatic test_mid_load();
    load_word(16'h3C96);
    run_frame(16'h3C96, 2, 1'b1, 16'h6B1E);
    run_frame(16'h6B1E, 2, 1'b0, 16'h0);
  endtask

  task automatic test_restart();
    load_word(16'hF00D);
    rd_req = 1'b1; tag = next_tag();
    step();
    rd_req = 1'b0;
    chk(sync_o == 1'b1, "R6 first sync", sync_o, 1);
    step();
    chk(data_o == 1'b1, "R6 msb of first word", data_o, 1);
    step();
    step();
    load_word(16'h0F5A);
    run_frame(16'h0F5A, 3, 1'b0, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; word = '0; load = 1'b0; rd_req = 1'b0; tag = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    step();
    test_reset();
    test_no_result_after_reset();
    test_patterns();
    test_no_result_in_tag();
    test_mid_load();
    test_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule